// File: doc/BRIEF.md
# LIN slave frame receive sequencer

This block follows a LIN frame on one receive line while the node acts as a slave. It samples the line once per bit-time strobe and moves through the parts of a frame in a fixed order: break, delimiter, sync byte, identifier, a configurable number of data bytes and the checksum. A 4-bit state code shows which part is being received, so software can read it at any time. The captured identifier and data bytes are held on the outputs.

Two buffer flags tell software when data are available. The not-empty flag rises as soon as the first data byte is stored. The ready flag rises when a complete response with a correct checksum has arrived. Software controls hold the block in an init state, put it to sleep and enable wake-up from the line.

When an error occurs, the block recovers according to the level of the sample that exposed it. A dominant sample sends it to break reception and a recessive sample sends it to idle. The receive line is expected to be synchronised to `clk` already. The reset input is asynchronous and is assumed to be released synchronously.

Top module: `lin_slave_rx_seq`

## Requirements
- R1: `state_o` encodes 0 sleep, 1 init, 2 idle, 3 break, 4 delimiter, 5 sync byte, 6 identifier, 7 header received, 8 data, 9 checksum. After reset the code is 1 and both buffer flags are 0.
- R2: Outside sleep, `init_i` high holds the state at 1 from the next clock edge. One cycle after `init_i` goes low the state becomes 2. While the state is 1, both buffer flags are cleared.
- R3: In state 2, a strobe that samples 0 when the previous strobe sampled 1 moves the state to 3.
- R4: In state 3 the block counts dominant samples, starting from the one that entered the state. The state moves to 4 on the 10th dominant sample when `brk_long_i`=0, and on the 11th when it is 1. A recessive sample before that point returns the state to 2.
- R5: In state 4, dominant samples keep the state at 4. The first recessive sample moves it to 5.
- R6: Each byte is sampled as a 0 start bit, 8 data bits with the LSB first and a 1 stop bit. Any number of recessive samples may come before a start bit.
- R7: A sync byte equal to 0x55 moves the state from 5 to 6. Any other value is an error.
- R8: A complete identifier byte is placed on `ident_o` and moves the state to 7. The next start bit moves the state to 8.
- R9: `data_len_i` (from 1 to MAX_DATA) data bytes are received. Byte k is placed on `data_o[8k+7:8k]`. After the last byte the state becomes 9.
- R10: The checksum byte is accepted when it matches the data. The check adds the data bytes and the checksum byte with end-around carry; the result must be 0xFF. A match returns the state to 2 and sets `buf_ready_o`. A mismatch is an error, and the flag stays unchanged.
- R11: On an error (a break that is too short, a 0 stop bit, a bad sync byte or a checksum mismatch) the state goes to 3 if the sample that revealed it was 0, and to 2 otherwise.
- R12: `buf_notempty_o` is set when the first data byte is stored. `clr_notempty_i` clears it, and `clr_ready_i` clears `buf_ready_o`. A clear has no effect on the other flag.
- R13: A rising edge of `sleep_i` moves the state to 0 from any state. The state leaves 0 for 2 when `sleep_i` and `init_i` are both low, or when `autowake_i` is high and a strobe samples 0. Otherwise it stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Synchronised receive line (0 dominant) |
| bit_tick_i | input | 1 | One-cycle strobe per bit time, the sample point |
| brk_long_i | input | 1 | 1 selects the 11-bit break threshold, 0 the 10-bit threshold |
| data_len_i | input | 4 | Number of data bytes in the response (1 to MAX_DATA) |
| init_i | input | 1 | Holds the block in init |
| sleep_i | input | 1 | Sleep request; its rising edge enters sleep |
| autowake_i | input | 1 | Enables wake-up on a dominant sample in sleep |
| clr_ready_i | input | 1 | Clears the ready flag |
| clr_notempty_i | input | 1 | Clears the not-empty flag |
| state_o | output | 4 | State code |
| ident_o | output | 8 | Captured identifier byte |
| data_o | output | 64 | Captured data bytes, byte k in bits 8k+7:8k |
| buf_ready_o | output | 1 | Response complete with a correct checksum |
| buf_notempty_o | output | 1 | At least one data byte stored |

## Verification
The bench builds the block with its default parameters: MAX_DATA of 8, and break thresholds of 10 and 11. With these values a response of 8 bytes fills every byte lane of `data_o`, so the last-byte index and the full storage width are both exercised. Both thresholds are reached at their exact sample counts, one sample before and at the boundary. Responses of 1 and 2 bytes cover the short end of the length range. A framing error in the identifier shows recovery into break reception with the counter restarted.

// File: rtl/lin_rx_pkg.sv
package lin_rx_pkg;

  typedef enum logic [3:0] {
    ST_SLEEP = 4'd0,
    ST_INIT  = 4'd1,
    ST_IDLE  = 4'd2,
    ST_BREAK = 4'd3,
    ST_DELIM = 4'd4,
    ST_SYNC  = 4'd5,
    ST_IDENT = 4'd6,
    ST_HDR   = 4'd7,
    ST_DATA  = 4'd8,
    ST_CKSUM = 4'd9
  } lin_state_e;

  localparam logic [7:0] SYNC_PATTERN = 8'h55;

  // 8-bit addition with the carry folded back into bit 0
  function automatic logic [7:0] wrap_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

endpackage

// File: rtl/lin_byte_rx.sv
module lin_byte_rx #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic                 tick_i,
  input  logic                 rx_i,
  output logic                 start_o,
  output logic                 done_o,
  output logic                 ferr_o,
  output logic [DATA_BITS-1:0] byte_o
);
  localparam int IW = $clog2(DATA_BITS + 1);

  logic                 busy_q, busy_d;
  logic [IW-1:0]        idx_q, idx_d;
  logic [DATA_BITS-1:0] sh_q, sh_d;
  logic                 sample, at_stop;

  always_comb begin
    sample  = en_i & tick_i;
    at_stop = busy_q & (idx_q == IW'(DATA_BITS));
    start_o = sample & ~busy_q & ~rx_i;
    done_o  = sample & at_stop & rx_i;
    ferr_o  = sample & at_stop & ~rx_i;
    busy_d  = busy_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    if (!en_i) begin
      busy_d = 1'b0;
      idx_d  = '0;
    end else if (start_o) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (sample && busy_q) begin
      if (at_stop) begin
        busy_d = 1'b0;
      end else begin
        sh_d  = {rx_i, sh_q[DATA_BITS-1:1]};
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
    end
  end

  assign byte_o = sh_q;

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start_o)); // R6

endmodule

// File: rtl/lin_cksum_acc.sv
module lin_cksum_acc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       add_i,
  input  logic [7:0] byte_i,
  input  logic [7:0] cks_i,
  output logic       match_o
);
  import lin_rx_pkg::*;

  logic [7:0] sum_q, sum_d;

  always_comb begin
    sum_d = sum_q;
    if (clr_i)      sum_d = 8'h00;
    else if (add_i) sum_d = wrap_add(sum_q, byte_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= 8'h00;
    else        sum_q <= sum_d;
  end

  assign match_o = (wrap_add(sum_q, cks_i) == 8'hFF);

endmodule

// File: rtl/lin_rx_flags.sv
module lin_rx_flags #(
  parameter int MAX_DATA = 8,
  parameter int IDXW     = $clog2(MAX_DATA)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init_clr_i,
  input  logic                  store_i,
  input  logic [IDXW-1:0]       idx_i,
  input  logic [7:0]            byte_i,
  input  logic                  set_ready_i,
  input  logic                  clr_ready_i,
  input  logic                  clr_ne_i,
  output logic                  ready_o,
  output logic                  ne_o,
  output logic [MAX_DATA*8-1:0] data_o
);
  logic ready_d, ne_d;

  always_comb begin
    ready_d = ready_o;
    ne_d    = ne_o;
    if (init_clr_i)       ready_d = 1'b0;
    else if (set_ready_i) ready_d = 1'b1;
    else if (clr_ready_i) ready_d = 1'b0;
    if (init_clr_i)       ne_d = 1'b0;
    else if (store_i)     ne_d = 1'b1;
    else if (clr_ne_i)    ne_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_o <= 1'b0;
      ne_o    <= 1'b0;
    end else begin
      ready_o <= ready_d;
      ne_o    <= ne_d;
    end
  end

  for (genvar k = 0; k < MAX_DATA; k++) begin : g_lane
    logic lane_en;
    assign lane_en = store_i && (idx_i == IDXW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_o[8*k +: 8] <= 8'h00;
      else if (lane_en) data_o[8*k +: 8] <= byte_i;
    end
  end

  AST_INIT_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr_i |=> (!ready_o && !ne_o)); // R2
  AST_NE_SET_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && !init_clr_i) |=> ne_o); // R12

endmodule

// File: rtl/lin_slave_rx_seq.sv
module lin_slave_rx_seq #(
  parameter int MAX_DATA  = 8,
  parameter int BRK_SHORT = 10,
  parameter int BRK_LONG  = 11,
  parameter int LENW      = $clog2(MAX_DATA + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_i,
  input  logic                  bit_tick_i,
  input  logic                  brk_long_i,
  input  logic [LENW-1:0]       data_len_i,
  input  logic                  init_i,
  input  logic                  sleep_i,
  input  logic                  autowake_i,
  input  logic                  clr_ready_i,
  input  logic                  clr_notempty_i,
  output logic [3:0]            state_o,
  output logic [7:0]            ident_o,
  output logic [MAX_DATA*8-1:0] data_o,
  output logic                  buf_ready_o,
  output logic                  buf_notempty_o
);
  import lin_rx_pkg::*;

  localparam int BRKW = $clog2(BRK_LONG + 1);
  localparam int IDXW = $clog2(MAX_DATA);

  lin_state_e      state_q, state_d, err_state;
  logic            last_q, sleep_q;
  logic [BRKW-1:0] cnt_q, cnt_d, brk_thr;
  logic [IDXW-1:0] didx_q, didx_d;
  logic [7:0]      ident_d;
  logic            rx_en, byte_start, byte_done, byte_ferr, last_byte, cks_match;
  logic            cks_clr, cks_add, store, set_ready, sleep_rise;
  logic [7:0]      rx_byte;

  assign brk_thr    = brk_long_i ? BRKW'(BRK_LONG) : BRKW'(BRK_SHORT);
  assign err_state  = rx_i ? ST_IDLE : ST_BREAK;
  assign sleep_rise = sleep_i & ~sleep_q;
  assign last_byte  = (LENW'(didx_q) + LENW'(1)) == data_len_i;
  assign rx_en      = (state_q == ST_SYNC) || (state_q == ST_IDENT) || (state_q == ST_HDR)
                   || (state_q == ST_DATA) || (state_q == ST_CKSUM);

  lin_byte_rx #(.DATA_BITS(8)) u_byte (
    .clk(clk), .rst_n(rst_n), .en_i(rx_en), .tick_i(bit_tick_i), .rx_i(rx_i),
    .start_o(byte_start), .done_o(byte_done), .ferr_o(byte_ferr), .byte_o(rx_byte)
  );

  lin_cksum_acc u_cks (
    .clk(clk), .rst_n(rst_n), .clr_i(cks_clr), .add_i(cks_add),
    .byte_i(rx_byte), .cks_i(rx_byte), .match_o(cks_match)
  );

  lin_rx_flags #(.MAX_DATA(MAX_DATA), .IDXW(IDXW)) u_flags (
    .clk(clk), .rst_n(rst_n), .init_clr_i(state_q == ST_INIT), .store_i(store),
    .idx_i(didx_q), .byte_i(rx_byte), .set_ready_i(set_ready),
    .clr_ready_i(clr_ready_i), .clr_ne_i(clr_notempty_i),
    .ready_o(buf_ready_o), .ne_o(buf_notempty_o), .data_o(data_o)
  );

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    didx_d    = didx_q;
    ident_d   = ident_o;
    cks_clr   = 1'b0;
    cks_add   = 1'b0;
    store     = 1'b0;
    set_ready = 1'b0;
    if (state_q == ST_SLEEP) begin
      if ((!sleep_i && !init_i) || (autowake_i && bit_tick_i && !rx_i)) state_d = ST_IDLE;
    end else if (sleep_rise) begin
      state_d = ST_SLEEP;
    end else if (init_i) begin
      state_d = ST_INIT;
    end else if (byte_ferr) begin
      state_d = err_state;
      cnt_d   = BRKW'(1);
    end else begin
      unique case (state_q)
        ST_INIT:  state_d = ST_IDLE;
        ST_IDLE:  if (bit_tick_i && !rx_i && last_q) begin
                    state_d = ST_BREAK;
                    cnt_d   = BRKW'(1);
                  end
        ST_BREAK: if (bit_tick_i) begin
                    if (rx_i)                        state_d = err_state;
                    else if (cnt_q + 1'b1 >= brk_thr) state_d = ST_DELIM;
                    else                             cnt_d = cnt_q + 1'b1;
                  end
        ST_DELIM: if (bit_tick_i && rx_i) begin
                    state_d = ST_SYNC;
                    cks_clr = 1'b1;
                  end
        ST_SYNC:  if (byte_done) state_d = (rx_byte == SYNC_PATTERN) ? ST_IDENT : err_state;
        ST_IDENT: if (byte_done) begin
                    ident_d = rx_byte;
                    state_d = ST_HDR;
                  end
        ST_HDR:   if (byte_start) begin
                    state_d = ST_DATA;
                    didx_d  = '0;
                  end
        ST_DATA:  if (byte_done) begin
                    store   = 1'b1;
                    cks_add = 1'b1;
                    if (last_byte) state_d = ST_CKSUM;
                    else           didx_d  = didx_q + 1'b1;
                  end
        ST_CKSUM: if (byte_done) begin
                    set_ready = cks_match;
                    state_d   = cks_match ? ST_IDLE : err_state;
                  end
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      last_q  <= 1'b1;
      sleep_q <= 1'b0;
      cnt_q   <= '0;
      didx_q  <= '0;
      ident_o <= 8'h00;
    end else begin
      state_q <= state_d;
      sleep_q <= sleep_i;
      cnt_q   <= cnt_d;
      didx_q  <= didx_d;
      ident_o <= ident_d;
      if (bit_tick_i) last_q <= rx_i;
    end
  end

  assign state_o = state_q;

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_q <= ST_CKSUM); // R1
  AST_DELIM_FROM_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DELIM && $past(state_q) != ST_DELIM) |-> $past(state_q) == ST_BREAK); // R4
  AST_DATA_FROM_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && $past(state_q) != ST_DATA) |-> $past(state_q) == ST_HDR); // R8
  AST_BREAK_ON_DOMINANT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BREAK && $past(state_q) != ST_BREAK) |-> !$past(rx_i)); // R11
  AST_READY_AFTER_CKSUM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_ready_o) |-> $past(state_q) == ST_CKSUM); // R10
  AST_SLEEP_EXIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_SLEEP && state_q != ST_SLEEP) |-> state_q == ST_IDLE); // R13

endmodule

// File: tb/lin_slave_rx_seq_bench.sv
module lin_slave_rx_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1, tick = 1'b0, brk_long = 1'b0;
  logic [3:0]  dlen = 4'd2;
  logic        init = 1'b1, sleep = 1'b0, awake = 1'b0, clr_rdy = 1'b0, clr_ne = 1'b0;
  logic [3:0]  state;
  logic [7:0]  ident;
  logic [63:0] data;
  logic        rdy, ne;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  lin_slave_rx_seq u_lin_slave_rx_seq (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .bit_tick_i(tick), .brk_long_i(brk_long),
    .data_len_i(dlen), .init_i(init), .sleep_i(sleep), .autowake_i(awake),
    .clr_ready_i(clr_rdy), .clr_notempty_i(clr_ne), .state_o(state), .ident_o(ident),
    .data_o(data), .buf_ready_o(rdy), .buf_notempty_o(ne)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx = b; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    send_bit(stop);
  endtask

  function automatic logic [7:0] cks_of(input logic [63:0] d, input int n);
    int s = 0;
    for (int i = 0; i < n; i++) begin
      s = s + d[8*i +: 8];
      if (s > 255) s = s - 255;
    end
    return ~s[7:0];
  endfunction

  task automatic send_header(input int zeros, input logic [7:0] id);
    send_bit(1'b1);
    for (int i = 0; i < zeros; i++) send_bit(1'b0);
    send_bit(1'b1);
    send_byte(8'h55, 1'b1);
    send_byte(id, 1'b1);
  endtask

  task automatic send_response(input logic [63:0] d, input int n, input logic [7:0] cks);
    for (int i = 0; i < n; i++) send_byte(d[8*i +: 8], 1'b1);
    send_byte(cks, 1'b1);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset state", state, 64'd1);
    chk("R1 reset ready", rdy, 64'd0);
    chk("R1 reset notempty", ne, 64'd0);
    @(negedge clk); init = 1'b0;
    @(negedge clk);
    chk("R2 init release to idle", state, 64'd2);
  endtask

  task automatic t_good_frame;
    logic [63:0] d = 64'h0F_A5;
    dlen = 4'd2; brk_long = 1'b0;
    send_bit(1'b1);
    send_bit(1'b0);
    chk("R3 break entry", state, 64'd3);
    for (int i = 0; i < 8; i++) send_bit(1'b0);
    chk("R4 nine dominant still break", state, 64'd3);
    send_bit(1'b0);
    chk("R4 tenth dominant to delimiter", state, 64'd4);
    send_bit(1'b1);
    chk("R5 recessive to sync", state, 64'd5);
    send_byte(8'h55, 1'b1);
    chk("R7 sync ok to ident", state, 64'd6);
    send_bit(1'b1);
    send_byte(8'h3A, 1'b1);
    chk("R8 header state", state, 64'd7);
    chk("R8 identifier value", ident, 64'h3A);
    send_bit(1'b1); send_bit(1'b1);
    chk("R6 idle bits keep header", state, 64'd7);
    send_byte(8'hA5, 1'b1);
    chk("R8 data state", state, 64'd8);
    chk("R12 notempty after first byte", ne, 64'd1);
    chk("R9 byte0 lane", data[7:0], 64'hA5);
    send_byte(8'h0F, 1'b1);
    chk("R9 checksum state", state, 64'd9);
    send_byte(cks_of(d, 2), 1'b1);
    chk("R10 idle after checksum", state, 64'd2);
    chk("R10 ready set", rdy, 64'd1);
    chk("R9 byte1 lane", data[15:8], 64'h0F);
  endtask

  task automatic t_flag_clear;
    pulse(clr_rdy);
    chk("R12 ready cleared", rdy, 64'd0);
    chk("R12 notempty kept", ne, 64'd1);
    pulse(clr_ne);
    chk("R12 notempty cleared", ne, 64'd0);
  endtask

  task automatic t_long_break_bad_sync;
    brk_long = 1'b1;
    send_bit(1'b1);
    for (int i = 0; i < 10; i++) send_bit(1'b0);
    chk("R4 long threshold not yet", state, 64'd3);
    send_bit(1'b0);
    chk("R4 eleventh dominant to delimiter", state, 64'd4);
    send_bit(1'b0);
    chk("R5 dominant keeps delimiter", state, 64'd4);
    send_bit(1'b1);
    send_byte(8'h54, 1'b1);
    chk("R7 bad sync to idle", state, 64'd2);
    brk_long = 1'b0;
  endtask

  task automatic t_short_break;
    send_bit(1'b1);
    for (int i = 0; i < 6; i++) send_bit(1'b0);
    send_bit(1'b1);
    chk("R11 short break to idle", state, 64'd2);
  endtask

  task automatic t_framing_then_full;
    logic [63:0] d = 64'h08_07_06_05_04_03_02_01;
    dlen = 4'd8;
    send_bit(1'b1);
    for (int i = 0; i < 10; i++) send_bit(1'b0);
    send_bit(1'b1);
    send_byte(8'h55, 1'b1);
    send_byte(8'h22, 1'b0);
    chk("R11 framing error to break", state, 64'd3);
    for (int i = 0; i < 9; i++) send_bit(1'b0);
    chk("R11 break recount reaches delimiter", state, 64'd4);
    send_bit(1'b1);
    send_byte(8'h55, 1'b1);
    send_byte(8'h11, 1'b1);
    chk("R8 identifier after recovery", ident, 64'h11);
    send_response(d, 8, cks_of(d, 8));
    chk("R9 eight bytes stored", data, d);
    chk("R10 ready after eight", rdy, 64'd1);
    chk("R10 idle after eight", state, 64'd2);
  endtask

  task automatic t_cks_error;
    logic [63:0] d = 64'h00_00_00_00_00_00_00_C3;
    pulse(clr_rdy); pulse(clr_ne);
    dlen = 4'd1;
    send_header(10, 8'h2B);
    send_response(d, 1, cks_of(d, 1) ^ 8'h01);
    chk("R10 mismatch to idle", state, 64'd2);
    chk("R10 mismatch no ready", rdy, 64'd0);
    chk("R12 notempty on bad checksum", ne, 64'd1);
  endtask

  task automatic t_init_clear;
    logic [63:0] d = 64'h00_00_00_00_00_00_00_7E;
    send_header(10, 8'h05);
    send_response(d, 1, cks_of(d, 1));
    chk("R10 single byte ready", rdy, 64'd1);
    @(negedge clk); init = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 init state", state, 64'd1);
    chk("R2 init clears ready", rdy, 64'd0);
    chk("R2 init clears notempty", ne, 64'd0);
    init = 1'b0;
    @(negedge clk);
    chk("R2 back to idle", state, 64'd2);
  endtask

  task automatic t_sleep;
    @(negedge clk); sleep = 1'b1;
    @(negedge clk);
    chk("R13 sleep entry", state, 64'd0);
    send_bit(1'b0);
    chk("R13 no autowake stays asleep", state, 64'd0);
    @(negedge clk); sleep = 1'b0;
    @(negedge clk);
    chk("R13 controls cleared to idle", state, 64'd2);
    send_bit(1'b1);
    @(negedge clk); sleep = 1'b1; awake = 1'b1;
    @(negedge clk);
    chk("R13 second sleep entry", state, 64'd0);
    send_bit(1'b1);
    chk("R13 recessive no wake", state, 64'd0);
    send_bit(1'b0);
    chk("R13 autowake to idle", state, 64'd2);
    repeat (3) @(negedge clk);
    chk("R13 stays awake while request held", state, 64'd2);
    sleep = 1'b0; awake = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good_frame();
    t_flag_clear();
    t_long_break_bad_sync();
    t_short_break();
    t_framing_then_full();
    t_cks_error();
    t_init_clear();
    t_sleep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule